// File: doc/BRIEF.md
# Fractional microsecond timebase counter

This block keeps a free-running microsecond count from a reference clock whose frequency need not be a whole number of megahertz. A rational prescaler issues (A+1) counter steps for every (B+1) reference cycles, so references such as 12.8, 16.8, 19.2 or 38.4 MHz still produce an exact 1 MHz step.

The prescaler is an accumulator. Each enabled reference cycle adds A+1 to a residue. When the sum reaches B+1, the block subtracts B+1 and advances the count by one. The block forces A to be no greater than B, so the count moves at most once per cycle.

Software reaches the block through a small register port. It can read the count, read and write the ratio, and set a run bit that starts the timer. The count wraps modulo 2^32 and needs no rate correction in software.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0, the ratio register reads 0x0000000C, the control register reads 0 and `rd_data` is 0.
- R2: The count stays frozen until bit 0 of the control register (offset 8) is written with 1. That bit can only be set. Writing 0 to it leaves it at 1 and the count keeps advancing. Only reset clears it.
- R3: After a ratio write, N enabled reference cycles later the count has grown by exactly floor(N*(A+1)/(B+1)). Over 1000 µs of reference cycles, each of the settings 0x000B (12 MHz), 0x043F (12.8 MHz), 0x0453 (16.8 MHz), 0x045F (19.2 MHz), 0x04BF (38.4 MHz) and 0x002F (48 MHz) gives exactly 1000 steps.
- R4: Every step adds exactly 1. After the first step, the gap between consecutive steps is floor or ceil of (B+1)/(A+1) reference cycles.
- R5: A ratio write clears the residue. No step happens on the write cycle, and the count value is kept across the write.
- R6: The ratio register sits at offset 4, with A in bits 15:8 and B in bits 7:0. A write whose A exceeds its B stores A equal to B, and the register reads back the clamped value. A ratio with A equal to B steps on every cycle.
- R7: The count at offset 0 is read-only. A write to it leaves the value unchanged.
- R8: `rd_data` changes one cycle after `rd_en`, with the register value from before that edge, and holds otherwise. Unmapped offsets read 0. Bits 31:16 of the ratio register are dropped on write and read 0.
- R9: The reset ratio is one step per 13 cycles. 130 cycles after the timer is enabled, the count reads 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Registered read data |

## Verification
A write takes effect at the edge that captures it. The count steps first on the following edge, while a read returns its value one edge after `rd_en`. So a read taken at edge W+N+1 after a ratio write at edge W shows the count after W+N. The bench samples every result at the falling edge after the edge that produces it. It computes expected counts as floor(N*(A+1)/(B+1)) from the number of edges since the write. Step spacing is watched on every falling edge while a read of the count is held continuously, and the first gap after a write is left out.

// File: rtl/usec_tb_pkg.sv
package usec_tb_pkg;
    localparam int RATIO_W = 8;
    localparam int CFG_W   = 2 * RATIO_W;

    localparam int OFF_CNT  = 0;
    localparam int OFF_CFG  = 4;
    localparam int OFF_CTRL = 8;

    typedef struct packed {
        logic [RATIO_W-1:0] a;   // steps per window, minus one
        logic [RATIO_W-1:0] b;   // cycles per window, minus one
    } ratio_t;

    localparam ratio_t RATIO_RST = '{a: 8'h00, b: 8'h0C};
endpackage

// File: rtl/usec_regif.sv
module usec_regif
    import usec_tb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt,
    output ratio_t            ratio,
    output logic              run,
    output logic              cfg_wr
);
    typedef struct packed {
        ratio_t            cfg;
        logic              run;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [RATIO_W-1:0] new_a, new_b;
    logic               hit_cfg, hit_ctrl;

    always_comb begin
        st_d     = st_q;
        new_b    = wr_data[RATIO_W-1:0];
        new_a    = wr_data[2*RATIO_W-1:RATIO_W];
        hit_cfg  = wr_en && (wr_addr == ADDR_W'(OFF_CFG));
        hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
        if (hit_cfg) begin
            st_d.cfg.b = new_b;
            st_d.cfg.a = (new_a > new_b) ? new_b : new_a;
        end
        if (hit_ctrl && wr_data[0]) begin
            st_d.run = 1'b1;
        end
        if (rd_en) begin
            if (rd_addr == ADDR_W'(OFF_CNT)) begin
                st_d.rdata = DATA_W'(cnt);
            end else if (rd_addr == ADDR_W'(OFF_CFG)) begin
                st_d.rdata = DATA_W'(st_q.cfg);
            end else if (rd_addr == ADDR_W'(OFF_CTRL)) begin
                st_d.rdata = DATA_W'(st_q.run);
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg   <= RATIO_RST;
            st_q.run   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign ratio   = st_q.cfg;
    assign run     = st_q.run;
    assign cfg_wr  = hit_cfg;

    p_sticky_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> st_q.run);
    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.a <= st_q.cfg.b);
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/usec_prescaler.sv
module usec_prescaler
    import usec_tb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   clear,
    input  ratio_t ratio,
    output logic   tick
);
    localparam int ACC_W = RATIO_W + 1;
    localparam int SUM_W = RATIO_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } pre_t;

    pre_t st_d, st_q;

    logic [SUM_W-1:0] sum, den;

    always_comb begin
        st_d = st_q;
        sum  = SUM_W'(st_q.acc) + SUM_W'(ratio.a) + SUM_W'(1);
        den  = SUM_W'(ratio.b) + SUM_W'(1);
        tick = 1'b0;
        if (clear) begin
            st_d.acc = '0;
        end else if (run) begin
            if (sum >= den) begin
                tick     = 1'b1;
                st_d.acc = ACC_W'(sum - den);
            end else begin
                st_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_residue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(st_q.acc) < den);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.acc == '0));
    p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run && !clear));
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);   // wraps modulo 2^CNT_W
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_tb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    ratio_t           ratio;
    logic             run, cfg_wr, tick;
    logic [CNT_W-1:0] cnt;

    usec_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt(cnt), .ratio(ratio), .run(run), .cfg_wr(cfg_wr)
    );

    usec_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(cfg_wr),
        .ratio(ratio), .tick(tick)
    );

    usec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt)
    );

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
    p_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(cnt));
endmodule

// File: tb/sim_usec_timebase.sv
module sim_usec_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;

    usec_timebase u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    localparam int NV = 6;
    localparam logic [15:0] VCFG [NV] = '{16'h000B, 16'h043F, 16'h0453,
                                          16'h045F, 16'h04BF, 16'h002F};
    localparam int VCYC [NV] = '{12000, 12800, 16800, 19200, 38400, 48000};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    // step-spacing monitor (R4)
    logic        mon = 1'b0;
    logic        first = 1'b0;
    logic [31:0] prev = '0;
    int          gap = 0, lo = 0, hi = 0, viol = 0;

    always @(negedge clk) begin
        if (mon) begin
            gap++;
            if (rd_data != prev) begin
                if (rd_data != prev + 32'd1) viol++;
                if (!first && (gap < lo || gap > hi)) viol++;
                first = 1'b0;
                gap   = 0;
                prev  = rd_data;
            end
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, p, c0;
        int a1, b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data", rd_data, 32'h0);
        rd(4'd4, v);  check("R1 R9 cfg reset", v, 32'h0000000C);
        rd(4'd0, v);  check("R1 count reset", v, 32'h0);
        rd(4'd8, v);  check("R1 ctrl reset", v, 32'h0);

        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);  check("R7 count write ignored", v, 32'h0);
        repeat (50) @(negedge clk);
        rd(4'd0, v);  check("R2 frozen before enable", v, 32'h0);
        rd(4'd12, v); check("R8 unmapped reads 0", v, 32'h0);

        wr(4'd8, 32'h1);
        repeat (130) @(posedge clk);
        @(negedge clk);
        rd(4'd0, v);  check("R9 default ratio 130 cycles", v, 32'd10);

        wr(4'd8, 32'h0);
        rd(4'd8, v);  check("R2 enable write-0 ignored", v, 32'h1);
        rd(4'd0, v);
        repeat (25) @(posedge clk);
        @(negedge clk);
        rd(4'd0, v2); check("R2 still running", v2 - v, 32'd2);

        wr(4'd4, 32'h0000_0503);
        rd(4'd4, v);  check("R6 clamp A to B", v, 32'h0000_0303);
        rd(4'd0, v);
        repeat (9) @(posedge clk);
        @(negedge clk);
        rd(4'd0, v2); check("R6 A equal B steps each cycle", v2 - v, 32'd10);

        wr(4'd4, 32'hABCD_000C);
        rd(4'd4, v);  check("R8 upper cfg bits dropped", v, 32'h0000_000C);

        rd_addr = 4'd0;
        rd_en   = 1'b1;
        for (int i = 0; i < NV; i++) begin
            a1 = int'(VCFG[i][15:8]) + 1;
            b1 = int'(VCFG[i][7:0]) + 1;
            lo = b1 / a1;
            hi = lo + ((b1 % a1) != 0 ? 1 : 0);
            wr_en = 1'b1; wr_addr = 4'd4; wr_data = {16'h0, VCFG[i]};
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            p = rd_data;
            @(posedge clk);
            @(negedge clk);
            c0 = rd_data;
            check($sformatf("R5 count kept across write cfg=%04h", VCFG[i]), c0, p);
            viol = 0; gap = 0; prev = c0; first = 1'b1; mon = 1'b1;
            repeat (VCYC[i]) @(posedge clk);
            @(negedge clk);
            mon = 1'b0;
            check($sformatf("R3 steps in 1000us cfg=%04h", VCFG[i]), rd_data - c0, 32'd1000);
            check($sformatf("R4 spacing violations cfg=%04h", VCFG[i]), 32'(viol), 32'd0);
        end
        rd_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule